// File: doc/BRIEF.md
# Host Interrupt Status and Mask Unit

This unit gathers single-cycle event pulses from up to 22 internal sources into sticky pending bits. It drives one host interrupt line that is active while any pending bit is not blocked by the mask. The host reaches the unit through a small register bus: a read strobe, a write strobe, a word address, and write and read data. Read data is combinational and valid in the cycle of the read strobe. Side effects of a read or write take place at the clock edge that ends that cycle.

The same pending bits and mask are reached through several register views, each with its own side effect:
- a plain read/write mask;
- set-only and clear-only mask aliases;
- a status peek that changes nothing;
- a status take that clears every pending bit;
- a write-one-to-acknowledge register.

Only the source positions that exist are built. The default set is 0 to 10, 14, 16 and 17. Every other position reads 0 in all views and cannot be set. The output polarity is chosen by a configuration pin.

Top module: `hirq_unit`

## Requirements
- R1: After reset the mask reads 0x0000_0001 (only source 0 blocked), no bit is pending, and the interrupt output is at its inactive level.
- R2: A write to word address 0 loads the mask from the write data; a read of address 0 returns the mask. A mask bit of 1 blocks its source, 0 lets it through.
- R3: A write to address 1 sets each mask bit whose data bit is 1 and keeps every other mask bit.
- R4: A write to address 2 clears each mask bit whose data bit is 1 and keeps every other mask bit.
- R5: A read of address 3 returns the pending bits and leaves them unchanged.
- R6: A read of address 4 returns the pending bits, and at the end of that cycle every pending bit is cleared.
- R7: A write to address 5 clears each pending bit whose data bit is 1; bits written 0 stay pending. The clear is visible through both address 3 and address 4.
- R8: A source pulse sets its pending bit at the next edge. When a pulse and a clear (acknowledge or take) hit the same bit in the same cycle, the bit ends up set.
- R9: The internal interrupt level is registered: one clock after any pending bit is present with its mask bit 0, the level is asserted; one clock after there is none, it is released.
- R10: The pin `irq_active_low` selects the output polarity. When it is 0 the output is high while the level is asserted; when it is 1 the output is low while the level is asserted.
- R11: `rd_data` is 0 when `rd_en` is low, and on reads of the write-only addresses 1, 2 and 5 and of unmapped addresses 6 and 7. Writes to addresses 3, 4, 6 and 7 change nothing.
- R12: Positions not in the implemented set (by default 11 to 13, 15 and 18 to 21) and all bits above 21 read 0 in the mask and status views. Pulses and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 22 | Single-cycle event pulses, one per source position |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address of the register view |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the cycle of `rd_en` |
| irq_active_low | input | 1 | Output polarity select |
| host_irq | output | 1 | Host interrupt line |

## Verification
On every cycle, the assertions check the following:
- a pulsed source is pending one edge later, even against a concurrent clear;
- a take read with no pulses leaves nothing pending;
- a peek never drops a bit;
- the set and clear aliases reach the written bits;
- an empty status releases the interrupt level;
- write-only addresses read zero.

Only the bench's scenarios show that the aliases leave other bits alone and that acknowledge is selective. They also show the reset value of the mask, the masking of source 0, the polarity flip and the inertness of reserved positions. The bench shows these by comparing every cycle against its behavioural model.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

  localparam int unsigned HIRQ_NSRC = 22;
  localparam int unsigned HIRQ_DW   = 32;
  localparam int unsigned HIRQ_AW   = 3;

  // Source positions (bit index in every status and mask view)
  localparam int unsigned SRC_RXBUF0   = 0;
  localparam int unsigned SRC_TXDATA   = 1;
  localparam int unsigned SRC_TXMOVE   = 2;
  localparam int unsigned SRC_RXBUF1   = 3;
  localparam int unsigned SRC_RXMOVE   = 4;
  localparam int unsigned SRC_MBOX0    = 5;
  localparam int unsigned SRC_MBOX1    = 6;
  localparam int unsigned SRC_WAKE     = 7;
  localparam int unsigned SRC_TRACE0   = 8;
  localparam int unsigned SRC_TRACE1   = 9;
  localparam int unsigned SRC_CMDDONE  = 10;
  localparam int unsigned SRC_INITDONE = 14;
  localparam int unsigned SRC_SENSE_ON = 16;
  localparam int unsigned SRC_SENSE_OFF= 17;

  localparam logic [HIRQ_NSRC-1:0] HIRQ_IMPL_DEFAULT =
      HIRQ_NSRC'((1 << SRC_RXBUF0) | (1 << SRC_TXDATA) | (1 << SRC_TXMOVE) |
                 (1 << SRC_RXBUF1) | (1 << SRC_RXMOVE) | (1 << SRC_MBOX0) |
                 (1 << SRC_MBOX1) | (1 << SRC_WAKE) | (1 << SRC_TRACE0) |
                 (1 << SRC_TRACE1) | (1 << SRC_CMDDONE) | (1 << SRC_INITDONE) |
                 (1 << SRC_SENSE_ON) | (1 << SRC_SENSE_OFF));

  localparam logic [HIRQ_NSRC-1:0] HIRQ_MASK_RESET = HIRQ_NSRC'(1);

  typedef enum logic [HIRQ_AW-1:0] {
    VIEW_MASK     = 3'd0,
    VIEW_MASK_SET = 3'd1,
    VIEW_MASK_CLR = 3'd2,
    VIEW_PEEK     = 3'd3,
    VIEW_TAKE     = 3'd4,
    VIEW_ACK      = 3'd5
  } hirq_view_e;

endpackage

// File: rtl/hirq_rst_sync.sv
module hirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hirq_regif.sv
module hirq_regif
  import hirq_pkg::*;
#(
  parameter int unsigned NSRC = HIRQ_NSRC,
  parameter int unsigned DW   = HIRQ_DW,
  parameter int unsigned AW   = HIRQ_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NSRC-1:0] status,
  input  logic [NSRC-1:0] mask,
  output logic [DW-1:0]   rd_data,
  output logic            mask_load,
  output logic            mask_set,
  output logic            mask_clr,
  output logic            ack_wr,
  output logic            take_rd,
  output logic            peek_rd,
  output logic [NSRC-1:0] wr_bits
);
  localparam int unsigned PAD = DW - NSRC;

  always_comb begin
    mask_load = wr_en && (addr == VIEW_MASK);
    mask_set  = wr_en && (addr == VIEW_MASK_SET);
    mask_clr  = wr_en && (addr == VIEW_MASK_CLR);
    ack_wr    = wr_en && (addr == VIEW_ACK);
    peek_rd   = rd_en && (addr == VIEW_PEEK);
    take_rd   = rd_en && (addr == VIEW_TAKE);
    wr_bits   = wr_data[NSRC-1:0];
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        VIEW_MASK: rd_data = {{PAD{1'b0}}, mask};
        VIEW_PEEK,
        VIEW_TAKE: rd_data = {{PAD{1'b0}}, status};
        default:   rd_data = '0;
      endcase
    end
  end

  // R11
  wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == VIEW_MASK_SET || addr == VIEW_MASK_CLR ||
               addr == VIEW_ACK || addr > VIEW_ACK)) |-> (rd_data == '0));
endmodule

// File: rtl/hirq_mask_reg.sv
module hirq_mask_reg
  import hirq_pkg::*;
#(
  parameter int unsigned     NSRC = HIRQ_NSRC,
  parameter logic [NSRC-1:0] IMPL = HIRQ_IMPL_DEFAULT,
  parameter logic [NSRC-1:0] RST  = HIRQ_MASK_RESET
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            set,
  input  logic            clr,
  input  logic [NSRC-1:0] bits,
  output logic [NSRC-1:0] mask
);
  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    if (IMPL[k]) begin : g_live
      logic q, d, en;
      always_comb begin
        en = load | ((set | clr) & bits[k]);
        d  = load ? bits[k] : set;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RST[k];
        else if (en) q <= d;
      end
      assign mask[k] = q;
    end else begin : g_rsvd
      assign mask[k] = 1'b0;
    end
  end

  // R3
  set_reaches_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> ((mask & $past(bits & IMPL)) == $past(bits & IMPL)));

  // R4
  clr_reaches_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((mask & $past(bits)) == '0));
endmodule

// File: rtl/hirq_status_bank.sv
module hirq_status_bank
  import hirq_pkg::*;
#(
  parameter int unsigned     NSRC = HIRQ_NSRC,
  parameter logic [NSRC-1:0] IMPL = HIRQ_IMPL_DEFAULT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            ack_wr,
  input  logic [NSRC-1:0] ack_bits,
  input  logic            take_rd,
  input  logic            peek_rd,
  output logic [NSRC-1:0] status
);
  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    if (IMPL[k]) begin : g_live
      logic q, d, en, wipe;
      always_comb begin
        wipe = take_rd | (ack_wr & ack_bits[k]);
        en   = evt[k] | wipe;
        d    = evt[k];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (en) q <= d;
      end
      assign status[k] = q;

      // R8
      evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[k] |=> status[k]);
    end else begin : g_rsvd
      assign status[k] = 1'b0;
    end
  end

  // R6
  take_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_rd && evt == '0) |=> (status == '0));

  // R5
  peek_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_rd && !take_rd && !ack_wr) |=>
      ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/hirq_unit.sv
module hirq_unit
  import hirq_pkg::*;
#(
  parameter int unsigned     NSRC     = HIRQ_NSRC,
  parameter int unsigned     DW       = HIRQ_DW,
  parameter int unsigned     AW       = HIRQ_AW,
  parameter logic [NSRC-1:0] IMPL     = HIRQ_IMPL_DEFAULT,
  parameter logic [NSRC-1:0] MASK_RST = HIRQ_MASK_RESET
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  input  logic            irq_active_low,
  output logic            host_irq
);
  logic            rst_i_n;
  logic [NSRC-1:0] status, mask, wr_bits;
  logic            mask_load, mask_set, mask_clr, ack_wr, take_rd, peek_rd;
  logic            irq_q, irq_d;

  hirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  hirq_regif #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regif (
    .clk(clk), .rst_n(rst_i_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .status(status), .mask(mask), .rd_data(rd_data),
    .mask_load(mask_load), .mask_set(mask_set), .mask_clr(mask_clr),
    .ack_wr(ack_wr), .take_rd(take_rd), .peek_rd(peek_rd), .wr_bits(wr_bits)
  );

  hirq_mask_reg #(.NSRC(NSRC), .IMPL(IMPL), .RST(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_i_n), .load(mask_load), .set(mask_set),
    .clr(mask_clr), .bits(wr_bits), .mask(mask)
  );

  hirq_status_bank #(.NSRC(NSRC), .IMPL(IMPL)) u_stat (
    .clk(clk), .rst_n(rst_i_n), .evt(evt_i), .ack_wr(ack_wr),
    .ack_bits(wr_bits), .take_rd(take_rd), .peek_rd(peek_rd), .status(status)
  );

  always_comb begin
    irq_d = |(status & ~mask);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign host_irq = irq_q ^ irq_active_low;

  // R9
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (status == '0) |=> !irq_q);
endmodule

// File: tb/hirq_unit_tb_top.sv
module hirq_unit_tb_top;
  localparam int unsigned NSRC = 22;
  localparam logic [31:0] IMPL = 32'h0003_47FF;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] evt_i;
  logic            rd_en, wr_en, irq_active_low;
  logic [2:0]      addr;
  logic [31:0]     wr_data, rd_data;
  logic            host_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural model state
  logic [31:0] m_mask;
  logic [31:0] m_stat;
  bit          m_irq;

  always #2 clk = ~clk;

  hirq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq_active_low(irq_active_low), .host_irq(host_irq)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive after negedge, check mid-cycle, advance model at posedge.
  task automatic step(string tag, logic [21:0] ev, bit rd, bit wr,
                      logic [2:0] a, logic [31:0] d);
    logic [31:0] exp_rd, clr;
    @(negedge clk);
    evt_i = ev; rd_en = rd; wr_en = wr; addr = a; wr_data = d;
    #1;
    exp_rd = 32'h0;
    if (rd) begin
      if (a == 3'd0) exp_rd = m_mask;
      else if (a == 3'd3 || a == 3'd4) exp_rd = m_stat;
    end
    check(tag, "rd_data", rd_data, exp_rd);
    check(tag, "host_irq", {31'h0, host_irq}, {31'h0, m_irq ^ irq_active_low});
    @(posedge clk);
    m_irq = ((m_stat & ~m_mask) != 0);
    if (wr) begin
      if (a == 3'd0) m_mask = d & IMPL;
      else if (a == 3'd1) m_mask = m_mask | (d & IMPL);
      else if (a == 3'd2) m_mask = m_mask & ~d;
    end
    clr = 32'h0;
    if (rd && a == 3'd4) clr = 32'hFFFF_FFFF;
    if (wr && a == 3'd5) clr = clr | d;
    m_stat = ((m_stat & ~clr) | {10'h0, ev}) & IMPL;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, '0, 1'b0, 1'b0, 3'd0, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; evt_i = '0; rd_en = 0; wr_en = 0; addr = 0; wr_data = 0;
    irq_active_low = 1'b0;
    m_mask = 32'h1; m_stat = 32'h0; m_irq = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    step("R1", '0, 1, 0, 3'd0, 0);
    step("R1", '0, 1, 0, 3'd3, 0);

    // R9 source 0 masked at reset, source 1 raises the line
    step("R9", 22'h1, 0, 0, 3'd0, 0);
    idle("R9", 2);
    step("R9", 22'h2, 0, 0, 3'd0, 0);
    idle("R9", 2);
    step("R5", '0, 1, 0, 3'd3, 0);
    step("R5", '0, 1, 0, 3'd3, 0);

    // R2 full mask load, R12 reserved mask bits read zero
    step("R2", '0, 0, 1, 3'd0, 32'hFFFF_FFFF);
    step("R12", '0, 1, 0, 3'd0, 0);
    idle("R9", 2);

    // R4 clear alias then R3 set alias
    step("R4", '0, 0, 1, 3'd2, 32'h0000_0002);
    step("R4", '0, 1, 0, 3'd0, 0);
    idle("R4", 2);
    step("R3", '0, 0, 1, 3'd1, 32'h0000_4002);
    step("R3", '0, 1, 0, 3'd0, 0);
    idle("R3", 2);
    step("R2", '0, 0, 1, 3'd0, 32'h0000_0001);
    idle("R2", 2);

    // R7 selective acknowledge, seen by both views
    step("R7", 22'h3_0400, 0, 0, 3'd0, 0);
    step("R7", '0, 0, 1, 3'd5, 32'h0000_0401);
    step("R7", '0, 1, 0, 3'd3, 0);
    step("R7", '0, 1, 0, 3'd4, 0);
    step("R6", '0, 1, 0, 3'd3, 0);
    idle("R9", 2);

    // R6 take read clears everything
    step("R6", 22'h0_40F0, 0, 0, 3'd0, 0);
    step("R6", 22'h0_0008, 1, 0, 3'd4, 0);
    step("R6", '0, 1, 0, 3'd4, 0);
    step("R6", '0, 1, 0, 3'd3, 0);
    idle("R6", 2);

    // R8 event beats a concurrent clear
    step("R8", 22'h0_0004, 0, 0, 3'd0, 0);
    step("R8", 22'h0_0004, 0, 1, 3'd5, 32'h0000_0004);
    step("R8", '0, 1, 0, 3'd3, 0);
    step("R8", 22'h0_0200, 1, 0, 3'd4, 0);
    step("R8", '0, 1, 0, 3'd3, 0);
    idle("R8", 2);

    // R10 polarity
    irq_active_low = 1'b1;
    idle("R10", 2);
    step("R10", '0, 1, 0, 3'd4, 0);
    idle("R10", 2);
    irq_active_low = 1'b0;

    // R11 write-only and unmapped reads, writes to read-only views
    step("R11", 22'h0_0020, 0, 0, 3'd0, 0);
    for (int a = 1; a < 8; a++) begin
      if (a != 3 && a != 4) step("R11", '0, 1, 0, 3'(a), 0);
    end
    step("R11", '0, 0, 1, 3'd3, 32'hFFFF_FFFF);
    step("R11", '0, 0, 1, 3'd4, 32'hFFFF_FFFF);
    step("R11", '0, 0, 1, 3'd6, 32'hFFFF_FFFF);
    step("R11", '0, 0, 1, 3'd7, 32'hFFFF_FFFF);
    step("R11", '0, 1, 0, 3'd3, 0);
    step("R11", '0, 1, 0, 3'd0, 0);
    step("R11", '0, 1, 0, 3'd0, 0);
    step("R11", '0, 0, 1, 3'd5, 32'hFFFF_FFFF);

    // R12 reserved positions ignore pulses
    step("R12", 22'h3C_B800, 0, 0, 3'd0, 0);
    step("R12", '0, 1, 0, 3'd3, 0);
    idle("R12", 3);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule